// File: doc/BRIEF.md
# Load-Use Hazard Detection Unit

This block sits in the decode stage of an in-order five-stage integer pipeline. Each cycle it compares the source registers of the instruction in decode with the destination of the instruction in execute. When the result the decode instruction needs cannot be forwarded in time, it holds the front of the pipeline for one cycle and turns the slot entering execute into a bubble. The fetch program counter and the fetch/decode register stay frozen, and the control bits loaded into the decode/execute register are cleared.

Two situations cause a hold. The first is a load in execute whose loaded value a following instruction reads. This includes a store that takes its data operand from that load, because store data is not forwarded into the memory stage. The second is a conditional branch, resolved in decode, that reads the result of an ALU instruction directly ahead of it in execute. The major opcode of the decode instruction decides which source fields are real register reads. Formats that carry no register sources never stall, and register zero never causes a stall. The unit is purely combinational, so the hold takes effect in the same cycle the hazard is seen. Once the load or ALU result has moved on to memory, the existing forwarding paths resolve the dependency.

Top module: `loaduse_hazard_unit`

## Requirements
- R1: When the execute instruction has both its memory-read and register-write flags set, and its nonzero destination equals a source register that the decode instruction reads, a stall is raised.
- R2: Source use follows the 7-bit major opcode. rs1 is read by register-register (0110011), immediate-arithmetic (0010011), load (0000011), indirect jump (1100111), store (0100011) and branch (1100011). rs2 is read only by register-register, store and branch. Any other opcode reads no source, and a match on a field that is not read never stalls.
- R3: Upper-immediate opcodes (0110111, 0010111) and the direct jump (1101111) never stall, whatever their register fields hold.
- R4: The PC write enable is 0 during a stall and 1 at all other times.
- R5: The fetch/decode write enable is 0 during a stall and 1 at all other times.
- R6: The decode/execute control-clear output is 1 during a stall and 0 otherwise. A stall lasts one cycle: once execute holds the bubble (flags low), the same decode instruction proceeds.
- R7: A store whose rs2 matches the destination of a load in execute stalls, even when its rs1 does not match.
- R8: A branch (1100011) whose rs1 or rs2 matches the nonzero destination of an execute instruction that writes a register without reading memory stalls. Non-branch instructions in the same situation do not stall.
- R9: An execute destination of register 0 never causes a stall.
- R10: No stall is raised when the execute register-write flag is 0, even if its memory-read flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_opcode | input | 7 | Major opcode of the instruction in decode |
| id_rs1 | input | AW | First source register field in decode |
| id_rs2 | input | AW | Second source register field in decode |
| ex_rd | input | AW | Destination register of the instruction in execute |
| ex_mem_read | input | 1 | Execute instruction reads data memory |
| ex_reg_write | input | 1 | Execute instruction writes the register file |
| pc_write_en | output | 1 | Program counter update enable |
| ifid_write_en | output | 1 | Fetch/decode pipeline register write enable |
| idex_ctrl_clear | output | 1 | Zero the control bits entering execute |

## Verification
The hardest case to reach is a register field that matches the execute destination but is not actually read by the decode opcode. Examples are an immediate instruction whose rs2 field aliases the load destination, or an upper-immediate instruction whose fields both match. Uniform random register numbers almost never produce these coincidences. The random stimulus therefore draws register numbers from a range of four values, which makes matches and register-zero cases frequent across every opcode class, including one unknown opcode. Directed cases then pin each alias, the store-data case, and the bubble cycle that follows a stall.

// File: rtl/hdu_pkg.sv
package hdu_pkg;

    localparam int OPC_W = 7;

    localparam logic [OPC_W-1:0] OPC_REGREG = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMMALU = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_JUMPR  = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_UPPER  = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_PCUP   = 7'b0010111;
    localparam logic [OPC_W-1:0] OPC_JUMP   = 7'b1101111;

    typedef enum logic [2:0] {
        FMT_REG,
        FMT_IMM,
        FMT_STO,
        FMT_BRA,
        FMT_UPP,
        FMT_JMP,
        FMT_NONE
    } fmt_e;

    typedef struct packed {
        logic rs1_used;
        logic rs2_used;
        logic is_branch;
    } src_use_t;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic idex_clr;
    } stall_ctl_t;

    function automatic fmt_e classify(input logic [OPC_W-1:0] opc);
        fmt_e f;
        case (opc)
            OPC_REGREG:                      f = FMT_REG;
            OPC_IMMALU, OPC_LOAD, OPC_JUMPR: f = FMT_IMM;
            OPC_STORE:                       f = FMT_STO;
            OPC_BRANCH:                      f = FMT_BRA;
            OPC_UPPER, OPC_PCUP:             f = FMT_UPP;
            OPC_JUMP:                        f = FMT_JMP;
            default:                         f = FMT_NONE;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/hdu_src_decode.sv
module hdu_src_decode
    import hdu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output src_use_t         use_o
);

    src_use_t use_d;

    always_comb begin
        use_d = '0;
        unique case (classify(opcode))
            FMT_REG: begin
                use_d.rs1_used = 1'b1;
                use_d.rs2_used = 1'b1;
            end
            FMT_IMM: begin
                use_d.rs1_used = 1'b1;
            end
            FMT_STO: begin
                use_d.rs1_used = 1'b1;
                use_d.rs2_used = 1'b1;
            end
            FMT_BRA: begin
                use_d.rs1_used  = 1'b1;
                use_d.rs2_used  = 1'b1;
                use_d.is_branch = 1'b1;
            end
            FMT_UPP, FMT_JMP, FMT_NONE: begin
                use_d = '0;
            end
            default: use_d = '0;
        endcase
    end

    assign use_o = use_d;

endmodule

// File: rtl/hdu_reg_match.sv
module hdu_reg_match #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] src,
    input  logic [NSRC-1:0]         src_used,
    input  logic [AW-1:0]           dst,
    output logic [NSRC-1:0]         hit
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    logic dst_live_d;

    always_comb begin
        dst_live_d = (dst != ZERO_REG);
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic hit_d;
        always_comb begin
            hit_d = src_used[g] && dst_live_d && (src[g] == dst);
        end
        assign hit[g] = hit_d;
    end

endmodule

// File: rtl/hdu_stall_ctrl.sv
module hdu_stall_ctrl
    import hdu_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] hit,
    input  logic            is_branch,
    input  logic            ex_mem_read,
    input  logic            ex_reg_write,
    output stall_ctl_t      ctl
);

    typedef struct packed {
        logic       any_hit;
        logic       load_stall;
        logic       alu_stall;
        stall_ctl_t ctl;
    } ctrl_state_t;

    ctrl_state_t st_d;

    always_comb begin
        st_d            = '0;
        st_d.any_hit    = |hit;
        st_d.load_stall = st_d.any_hit && ex_reg_write && ex_mem_read;
        st_d.alu_stall  = st_d.any_hit && ex_reg_write && !ex_mem_read && is_branch;
        if (st_d.load_stall || st_d.alu_stall) begin
            st_d.ctl.pc_we    = 1'b0;
            st_d.ctl.ifid_we  = 1'b0;
            st_d.ctl.idex_clr = 1'b1;
        end else begin
            st_d.ctl.pc_we    = 1'b1;
            st_d.ctl.ifid_we  = 1'b1;
            st_d.ctl.idex_clr = 1'b0;
        end
    end

    assign ctl = st_d.ctl;

endmodule

// File: rtl/loaduse_hazard_unit.sv
module loaduse_hazard_unit
    import hdu_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [OPC_W-1:0] id_opcode,
    input  logic [AW-1:0]    id_rs1,
    input  logic [AW-1:0]    id_rs2,
    input  logic [AW-1:0]    ex_rd,
    input  logic             ex_mem_read,
    input  logic             ex_reg_write,
    output logic             pc_write_en,
    output logic             ifid_write_en,
    output logic             idex_ctrl_clear
);

    localparam int NSRC = 2;

    src_use_t                 src_use;
    logic [NSRC-1:0][AW-1:0]  src_vec;
    logic [NSRC-1:0]          used_vec;
    logic [NSRC-1:0]          hit_vec;
    stall_ctl_t               ctl;

    assign src_vec  = {id_rs2, id_rs1};
    assign used_vec = {src_use.rs2_used, src_use.rs1_used};

    hdu_src_decode u_dec (
        .opcode (id_opcode),
        .use_o  (src_use)
    );

    hdu_reg_match #(
        .AW   (AW),
        .NSRC (NSRC)
    ) u_match (
        .src      (src_vec),
        .src_used (used_vec),
        .dst      (ex_rd),
        .hit      (hit_vec)
    );

    hdu_stall_ctrl #(
        .NSRC (NSRC)
    ) u_ctrl (
        .hit          (hit_vec),
        .is_branch    (src_use.is_branch),
        .ex_mem_read  (ex_mem_read),
        .ex_reg_write (ex_reg_write),
        .ctl          (ctl)
    );

    assign pc_write_en     = ctl.pc_we;
    assign ifid_write_en   = ctl.ifid_we;
    assign idex_ctrl_clear = ctl.idex_clr;

endmodule

// File: rtl/hdu_checker.sv
module hdu_checker
    import hdu_pkg::*;
#(
    parameter int AW = 5
) (
    input logic [OPC_W-1:0] id_opcode,
    input logic [AW-1:0]    id_rs1,
    input logic [AW-1:0]    id_rs2,
    input logic [AW-1:0]    ex_rd,
    input logic             ex_mem_read,
    input logic             ex_reg_write,
    input logic             pc_write_en,
    input logic             ifid_write_en,
    input logic             idex_ctrl_clear
);

    always_comb begin
        if (ex_mem_read && ex_reg_write && ex_rd != '0 &&
            id_opcode == OPC_REGREG && id_rs1 == ex_rd)
            assert_load_use_rs1_R1: assert (!pc_write_en);

        if (id_opcode == OPC_IMMALU && id_rs1 != ex_rd)
            assert_unread_rs2_R2: assert (pc_write_en);

        if (id_opcode == OPC_UPPER || id_opcode == OPC_PCUP || id_opcode == OPC_JUMP)
            assert_no_src_formats_R3: assert (pc_write_en);

        assert_hold_pair_R5: assert (ifid_write_en == pc_write_en);

        assert_bubble_R6: assert (idex_ctrl_clear == !pc_write_en);

        if (ex_rd == '0)
            assert_zero_reg_R9: assert (pc_write_en);

        if (!ex_reg_write)
            assert_no_writer_R10: assert (pc_write_en);
    end

endmodule

bind loaduse_hazard_unit hdu_checker #(.AW(AW)) u_chk (
    .id_opcode       (id_opcode),
    .id_rs1          (id_rs1),
    .id_rs2          (id_rs2),
    .ex_rd           (ex_rd),
    .ex_mem_read     (ex_mem_read),
    .ex_reg_write    (ex_reg_write),
    .pc_write_en     (pc_write_en),
    .ifid_write_en   (ifid_write_en),
    .idex_ctrl_clear (idex_ctrl_clear)
);

// File: tb/loaduse_hazard_unit_test.sv
`timescale 1ns/1ps
module loaduse_hazard_unit_test;

    localparam int AW = 5;

    localparam logic [6:0] O_RR  = 7'b0110011;
    localparam logic [6:0] O_IMM = 7'b0010011;
    localparam logic [6:0] O_LD  = 7'b0000011;
    localparam logic [6:0] O_JR  = 7'b1100111;
    localparam logic [6:0] O_ST  = 7'b0100011;
    localparam logic [6:0] O_BR  = 7'b1100011;
    localparam logic [6:0] O_UP  = 7'b0110111;
    localparam logic [6:0] O_PCU = 7'b0010111;
    localparam logic [6:0] O_JMP = 7'b1101111;
    localparam logic [6:0] O_UNK = 7'b1110011;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [6:0]    opc = '0;
    logic [AW-1:0] rs1 = '0;
    logic [AW-1:0] rs2 = '0;
    logic [AW-1:0] rd  = '0;
    logic          mr  = 1'b0;
    logic          rw  = 1'b0;
    logic          pc_we;
    logic          ifid_we;
    logic          clr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    loaduse_hazard_unit #(.AW(AW)) uut (
        .id_opcode       (opc),
        .id_rs1          (rs1),
        .id_rs2          (rs2),
        .ex_rd           (rd),
        .ex_mem_read     (mr),
        .ex_reg_write    (rw),
        .pc_write_en     (pc_we),
        .ifid_write_en   (ifid_we),
        .idex_ctrl_clear (clr)
    );

    function automatic bit expect_stall(input logic [6:0] o, input logic [AW-1:0] a,
                                        input logic [AW-1:0] b, input logic [AW-1:0] d,
                                        input logic m, input logic w);
        bit u1 = 0, u2 = 0, br = 0, hit;
        case (o)
            O_RR, O_ST:         begin u1 = 1; u2 = 1; end
            O_BR:               begin u1 = 1; u2 = 1; br = 1; end
            O_IMM, O_LD, O_JR:  u1 = 1;
            default:            ;
        endcase
        hit = (d != 0) && ((u1 && a == d) || (u2 && b == d));
        return hit && w && (m || br);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic check_bit(input string tag, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b expected %0b (opc=%b rs1=%0d rs2=%0d rd=%0d mr=%0b rw=%0b)",
                     tag, what, got, exp, opc, rs1, rs2, rd, mr, rw);
        end
    endtask

    task automatic apply(input logic [6:0] o, input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input logic [AW-1:0] d, input logic m, input logic w, input string tag);
        bit s;
        @(negedge clk);
        opc = o; rs1 = a; rs2 = b; rd = d; mr = m; rw = w;
        #1;
        s = expect_stall(o, a, b, d, m, w);
        check_bit(tag, "pc_write_en R4", pc_we, !s);
        check_bit(tag, "ifid_write_en R5", ifid_we, !s);
        check_bit(tag, "idex_ctrl_clear R6", clr, s);
    endtask

    function automatic string tag_of(input logic [6:0] o, input logic [AW-1:0] d, input logic w);
        if (o == O_UP || o == O_PCU || o == O_JMP) return "R3";
        if (d == 0) return "R9";
        if (!w) return "R10";
        if (o == O_ST) return "R7";
        if (o == O_BR) return "R8";
        return "R2";
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [6:0] olist [10];
        olist = '{O_RR, O_IMM, O_LD, O_JR, O_ST, O_BR, O_UP, O_PCU, O_JMP, O_UNK};
        void'($urandom(32'd20240917));

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check_bit("R4", "reset pc_write_en", pc_we, 1'b1);
        check_bit("R5", "reset ifid_write_en", ifid_we, 1'b1);
        check_bit("R6", "reset idex_ctrl_clear", clr, 1'b0);
        rst = 1'b0;

        // R1: load-use on rs1 and on rs2
        apply(O_RR, 5'd5, 5'd7, 5'd5, 1, 1, "R1");
        apply(O_RR, 5'd7, 5'd5, 5'd5, 1, 1, "R1");
        // R2: immediate form aliases rs2 only / really reads rs1
        apply(O_IMM, 5'd3, 5'd9, 5'd9, 1, 1, "R2");
        apply(O_IMM, 5'd9, 5'd3, 5'd9, 1, 1, "R2");
        apply(O_UNK, 5'd9, 5'd9, 5'd9, 1, 1, "R2");
        // R3: source-free formats
        apply(O_UP,  5'd4, 5'd4, 5'd4, 1, 1, "R3");
        apply(O_PCU, 5'd4, 5'd4, 5'd4, 1, 1, "R3");
        apply(O_JMP, 5'd4, 5'd4, 5'd4, 1, 1, "R3");
        // R7: store data from load
        apply(O_ST, 5'd2, 5'd11, 5'd11, 1, 1, "R7");
        // R8: branch on ALU producer; non-branch does not stall
        apply(O_BR, 5'd6, 5'd1, 5'd6, 0, 1, "R8");
        apply(O_BR, 5'd1, 5'd6, 5'd6, 0, 1, "R8");
        apply(O_RR, 5'd6, 5'd6, 5'd6, 0, 1, "R8");
        // R9: register zero
        apply(O_RR, 5'd0, 5'd0, 5'd0, 1, 1, "R9");
        apply(O_BR, 5'd0, 5'd0, 5'd0, 0, 1, "R9");
        // R10: no register write
        apply(O_RR, 5'd8, 5'd8, 5'd8, 1, 0, "R10");
        // R6: stall then bubble in execute, same decode instruction proceeds
        apply(O_LD, 5'd12, 5'd0, 5'd12, 1, 1, "R6");
        apply(O_LD, 5'd12, 5'd0, 5'd12, 0, 0, "R6");

        for (int i = 0; i < 800; i++) begin
            logic [6:0]    o;
            logic [AW-1:0] a, b, d;
            logic          m, w;
            o = olist[$urandom % 10];
            a = AW'($urandom % 4);
            b = AW'($urandom % 4);
            d = AW'($urandom % 4);
            m = 1'($urandom);
            w = 1'($urandom);
            apply(o, a, b, d, m, w, tag_of(o, d, w));
        end

        finish_run();
    end

endmodule